// File: doc/BRIEF.md
# SPI Command Queue Register Front End

This block is the software-facing half of a command-driven SPI controller. Software reaches it through a plain 32-bit register bus. It loads 16-bit sequencer commands and transmit words into two queues, and it collects the words the sequencer reads back from a third queue. A separate execution engine, outside this block, drains the command and transmit queues over valid/ready streams, fills the receive queue over a third stream, and reports the end of a program with a one-cycle sync event that carries an 8-bit tag.

Software can read how many free slots each outbound queue has and how many words wait in the inbound queue. It can look at the oldest receive word without consuming it. Four interrupt causes are latched in a pending register and cleared by writing ones to it: command queue running low, transmit queue running low, receive queue filling up, and sync completed. An enable mask gates them onto one interrupt line. A soft-reset register holds the engine and empties all three queues.

Stream rules: an outbound stream holds `valid` and keeps its data unchanged until the engine raises `ready`, and a word moves on a clock edge where both are high. The receive stream's `rxd_ready` is low while that queue is full or the block is held in soft reset. A word offered then is not taken, and the engine must keep offering it.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After `rst_n` is released, the soft-reset register (offset 0x40) reads 1, `eng_hold` is high, the enable register (0x80) reads 0 and `irq` is low.
- R2: Writing a value with bit 0 set to 0x40 holds the block in soft reset on the next cycle. All queues are emptied, `cmd_valid`, `txd_valid` and `rxd_ready` are low, and queue writes and receive pops are ignored. Writing bit 0 clear releases it.
- R3: Pending register 0x84 holds bit 0 = command queue low, bit 1 = transmit queue low, bit 2 = receive queue high, bit 3 = sync done. Writing 1 to a bit clears it (0xFF clears all), and writing 0 leaves it unchanged.
- R4: A `sync_valid` pulse outside soft reset sets pending bit 3 on the next cycle. A pulse during soft reset is ignored.
- R5: A sync event outside soft reset loads `sync_id` into the sync tag register at 0xC0, which reads it in bits [7:0].
- R6: A write to 0xE0 queues bits [15:0] of the write data as a command. Commands leave on the command stream in the order they were written, and 0xD0 reads depth minus occupancy.
- R7: A write to 0xE4 queues a transmit word. Transmit words leave on the transmit stream in the order they were written, and 0xD4 reads depth minus occupancy.
- R8: Words accepted on the receive stream are counted at 0xD8. A read of 0xE8 returns the oldest word and removes it. A read of 0xEC returns the oldest word and leaves the queue unchanged.
- R9: A write to a full queue is dropped. A read of 0xE8 on an empty receive queue returns 0. Neither changes the queue occupancy.
- R10: Pending bits 0 and 1 are set in every cycle that their queue holds at most a quarter of its depth. Pending bit 2 is set in every cycle that the receive queue holds at least depth minus a quarter of depth. A clear therefore does not remove a bit while its condition holds.
- R11: Enable register 0x80 holds bits [3:0] with the same layout as pending. `irq` is high exactly when some bit is both pending and enabled, and source register 0x88 reads pending AND enable.
- R12: While `cmd_valid` or `txd_valid` is high and the matching ready is low, valid stays high and the data stays unchanged on the next cycle, unless soft reset is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_rd | input | 1 | Register read strobe, one cycle per read (pops at 0xE8) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| cmd_valid | output | 1 | Command stream word available |
| cmd_ready | input | 1 | Engine takes the command word |
| cmd_data | output | CMD_W | Command word |
| txd_valid | output | 1 | Transmit stream word available |
| txd_ready | input | 1 | Engine takes the transmit word |
| txd_data | output | DATA_W | Transmit word |
| rxd_valid | input | 1 | Engine offers a receive word |
| rxd_ready | output | 1 | Receive queue accepts the word |
| rxd_data | input | DATA_W | Receive word |
| sync_valid | input | 1 | One-cycle sync completion event |
| sync_id | input | 8 | Tag carried by the sync event |
| eng_hold | output | 1 | Soft reset state, holds the engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with all three queues eight entries deep, so the low threshold is two words and the high threshold is six. At that depth a queue can be filled past full with a handful of register writes, which tests dropped pushes. A few receive words are enough to cross the high threshold and to show a cleared bit coming straight back. Command and transmit words are checked against scoreboard queues while the bench toggles ready, so stalls and in-order delivery are tested together.

// File: rtl/spife_pkg.sv
package spife_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFS_HOLD    = 8'h40;
  localparam logic [7:0] OFS_IEN     = 8'h80;
  localparam logic [7:0] OFS_IPEND   = 8'h84;
  localparam logic [7:0] OFS_ISRC    = 8'h88;
  localparam logic [7:0] OFS_TAG     = 8'hC0;
  localparam logic [7:0] OFS_CROOM   = 8'hD0;
  localparam logic [7:0] OFS_TROOM   = 8'hD4;
  localparam logic [7:0] OFS_RLVL    = 8'hD8;
  localparam logic [7:0] OFS_CPUSH   = 8'hE0;
  localparam logic [7:0] OFS_TPUSH   = 8'hE4;
  localparam logic [7:0] OFS_RPOP    = 8'hE8;
  localparam logic [7:0] OFS_RPEEK   = 8'hEC;

  localparam int N_IRQ    = 4;
  localparam int IB_CLOW  = 0;
  localparam int IB_TLOW  = 1;
  localparam int IB_RHIGH = 2;
  localparam int IB_SYNC  = 3;
endpackage

// File: rtl/spife_fifo.sv
module spife_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULLC);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign count   = cnt_q;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spife_irq.sv
module spife_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] enable,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      enable <= '0;
    end else begin
      pend <= (pend & ~clr_eff) | set;
      if (en_we) enable <= en_wdata;
    end
  end

  assign irq = |(pend & enable);
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
  import spife_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CMD_W     = 16,
  parameter int DATA_W    = 32,
  parameter int CMD_DEPTH = 16,
  parameter int TXD_DEPTH = 16,
  parameter int RXD_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              txd_valid,
  input  logic              txd_ready,
  output logic [DATA_W-1:0] txd_data,
  input  logic              rxd_valid,
  output logic              rxd_ready,
  input  logic [DATA_W-1:0] rxd_data,
  input  logic              sync_valid,
  input  logic [7:0]        sync_id,
  output logic              eng_hold,
  output logic              irq
);
  localparam int CCW = $clog2(CMD_DEPTH+1);
  localparam int TCW = $clog2(TXD_DEPTH+1);
  localparam int RCW = $clog2(RXD_DEPTH+1);
  localparam logic [CCW-1:0] CMD_LOW  = CCW'(CMD_DEPTH/4);
  localparam logic [TCW-1:0] TXD_LOW  = TCW'(TXD_DEPTH/4);
  localparam logic [RCW-1:0] RXD_HIGH = RCW'(RXD_DEPTH - RXD_DEPTH/4);

  logic              hold_q;
  logic [7:0]        tag_q;
  logic [7:0]        addr8;
  logic [CCW-1:0]    cmd_cnt;
  logic [TCW-1:0]    txd_cnt;
  logic [RCW-1:0]    rxd_cnt;
  logic              cmd_empty, cmd_full, txd_empty, txd_full, rxd_empty, rxd_full;
  logic [DATA_W-1:0] rxd_head;
  logic              sync_take;
  logic [N_IRQ-1:0]  irq_set, irq_pend, irq_en;

  assign addr8     = 8'(bus_addr);
  assign eng_hold  = hold_q;
  assign sync_take = sync_valid && !hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b1;
      tag_q  <= '0;
    end else begin
      if (bus_wr && addr8 == OFS_HOLD) hold_q <= bus_wdata[0];
      if (sync_take) tag_q <= sync_id;
    end
  end

  spife_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .clr(hold_q),
    .push(bus_wr && addr8 == OFS_CPUSH), .push_data(bus_wdata[CMD_W-1:0]),
    .pop(cmd_valid && cmd_ready), .head(cmd_data),
    .empty(cmd_empty), .full(cmd_full), .count(cmd_cnt)
  );

  spife_fifo #(.W(DATA_W), .DEPTH(TXD_DEPTH)) u_txdq (
    .clk(clk), .rst_n(rst_n), .clr(hold_q),
    .push(bus_wr && addr8 == OFS_TPUSH), .push_data(bus_wdata[DATA_W-1:0]),
    .pop(txd_valid && txd_ready), .head(txd_data),
    .empty(txd_empty), .full(txd_full), .count(txd_cnt)
  );

  spife_fifo #(.W(DATA_W), .DEPTH(RXD_DEPTH)) u_rxdq (
    .clk(clk), .rst_n(rst_n), .clr(hold_q),
    .push(rxd_valid && rxd_ready), .push_data(rxd_data),
    .pop(bus_rd && addr8 == OFS_RPOP), .head(rxd_head),
    .empty(rxd_empty), .full(rxd_full), .count(rxd_cnt)
  );

  assign cmd_valid = !cmd_empty && !hold_q;
  assign txd_valid = !txd_empty && !hold_q;
  assign rxd_ready = !rxd_full && !hold_q;

  always_comb begin
    irq_set           = '0;
    irq_set[IB_CLOW]  = (cmd_cnt <= CMD_LOW);
    irq_set[IB_TLOW]  = (txd_cnt <= TXD_LOW);
    irq_set[IB_RHIGH] = (rxd_cnt >= RXD_HIGH);
    irq_set[IB_SYNC]  = sync_take;
  end

  spife_irq #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set),
    .clr_we(bus_wr && addr8 == OFS_IPEND), .clr_mask(bus_wdata[N_IRQ-1:0]),
    .en_we(bus_wr && addr8 == OFS_IEN), .en_wdata(bus_wdata[N_IRQ-1:0]),
    .pend(irq_pend), .enable(irq_en), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (addr8)
      OFS_HOLD:  bus_rdata = REG_W'(hold_q);
      OFS_IEN:   bus_rdata = REG_W'(irq_en);
      OFS_IPEND: bus_rdata = REG_W'(irq_pend);
      OFS_ISRC:  bus_rdata = REG_W'(irq_pend & irq_en);
      OFS_TAG:   bus_rdata = REG_W'(tag_q);
      OFS_CROOM: bus_rdata = REG_W'(CMD_DEPTH) - REG_W'(cmd_cnt);
      OFS_TROOM: bus_rdata = REG_W'(TXD_DEPTH) - REG_W'(txd_cnt);
      OFS_RLVL:  bus_rdata = REG_W'(rxd_cnt);
      OFS_RPOP,
      OFS_RPEEK: bus_rdata = REG_W'(rxd_head);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spife_chk.sv
module spife_chk
  import spife_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [CMD_W-1:0]  cmd_data,
  input logic              txd_valid,
  input logic              txd_ready,
  input logic [DATA_W-1:0] txd_data,
  input logic              rxd_ready,
  input logic              sync_valid,
  input logic [7:0]        sync_id,
  input logic [7:0]        tag_q,
  input logic [3:0]        pend,
  input logic [3:0]        enable,
  input logic              eng_hold,
  input logic              irq
);
  logic hold_wr;
  assign hold_wr = bus_wr && 8'(bus_addr) == OFS_HOLD && bus_wdata[0];

  // R2: held engine sees no stream activity
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    eng_hold |-> (!cmd_valid && !txd_valid && !rxd_ready));

  // R3: write-one clears the sync bit when no new event arrives
  a_r3_w1c_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && 8'(bus_addr) == OFS_IPEND && bus_wdata[IB_SYNC] && !sync_valid)
    |=> !pend[IB_SYNC]);

  // R4: accepted sync event sets its pending bit
  a_r4_sync_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && !eng_hold) |=> pend[IB_SYNC]);

  // R5: tag register captures the event argument
  a_r5_tag_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_valid && !eng_hold) |=> (tag_q == $past(sync_id)));

  // R11: no interrupt with an empty mask
  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);

  // R12: stalled command word held steady
  a_r12_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !hold_wr) |=> (cmd_valid && $stable(cmd_data)));

  // R12: stalled transmit word held steady
  a_r12_txd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_valid && !txd_ready && !hold_wr) |=> (txd_valid && $stable(txd_data)));
endmodule

bind spi_cmd_frontend spife_chk #(.ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
  .txd_valid(txd_valid), .txd_ready(txd_ready), .txd_data(txd_data),
  .rxd_ready(rxd_ready), .sync_valid(sync_valid), .sync_id(sync_id),
  .tag_q(tag_q), .pend(irq_pend), .enable(irq_en), .eng_hold(eng_hold), .irq(irq)
);

// File: tb/spi_cmd_frontend_tb.sv
module spi_cmd_frontend_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [15:0] cmd_data;
  logic        txd_valid, txd_ready = 1'b0;
  logic [31:0] txd_data;
  logic        rxd_valid = 1'b0, rxd_ready;
  logic [31:0] rxd_data = '0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id = '0;
  logic        eng_hold, irq;

  int checks = 0;
  int errors = 0;
  logic [15:0] cmd_exp[$];
  logic [31:0] txd_exp[$];
  logic [31:0] rv;

  always #4 clk = ~clk;

  spi_cmd_frontend #(.CMD_DEPTH(DEPTH), .TXD_DEPTH(DEPTH), .RXD_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .txd_valid(txd_valid), .txd_ready(txd_ready), .txd_data(txd_data),
    .rxd_valid(rxd_valid), .rxd_ready(rxd_ready), .rxd_data(rxd_data),
    .sync_valid(sync_valid), .sync_id(sync_id), .eng_hold(eng_hold), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [31:0] d);
    @(posedge clk); #1;
    rxd_valid = 1'b1; rxd_data = d;
    forever begin
      @(negedge clk);
      if (rxd_ready) break;
    end
    @(posedge clk); #1;
    rxd_valid = 1'b0;
  endtask

  task automatic sync_evt(input logic [7:0] id);
    @(posedge clk); #1;
    sync_valid = 1'b1; sync_id = id;
    @(posedge clk); #1;
    sync_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitors: R6/R7 ordering, R12 stall stability
  logic        c_stall = 1'b0, t_stall = 1'b0;
  logic [15:0] c_held;
  logic [31:0] t_held;
  always @(negedge clk) begin
    if (rst_n && !eng_hold) begin
      if (c_stall) chk("R12 cmd held", {cmd_valid, 15'd0, cmd_data}, {1'b1, 15'd0, c_held});
      if (t_stall) begin
        chk("R12 txd valid held", {31'd0, txd_valid}, 32'd1);
        chk("R12 txd data held", txd_data, t_held);
      end
      if (cmd_valid && cmd_ready) begin
        if (cmd_exp.size() == 0) chk("R6 unexpected cmd", {16'd0, cmd_data}, 32'hFFFF_FFFF);
        else chk("R6 cmd order", {16'd0, cmd_data}, {16'd0, cmd_exp.pop_front()});
      end
      if (txd_valid && txd_ready) begin
        if (txd_exp.size() == 0) chk("R7 unexpected txd", txd_data, 32'hFFFF_FFFF);
        else chk("R7 txd order", txd_data, txd_exp.pop_front());
      end
      c_stall = cmd_valid && !cmd_ready; c_held = cmd_data;
      t_stall = txd_valid && !txd_ready; t_held = txd_data;
    end else begin
      c_stall = 1'b0; t_stall = 1'b0;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(8'h40, rv); chk("R1 hold reg", rv, 32'd1);
    chk("R1 eng_hold", {31'd0, eng_hold}, 32'd1);
    rd(8'h80, rv); chk("R1 enable reg", rv, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr(8'h40, 32'd0);
    rd(8'hD0, rv); chk("R6 empty room", rv, DEPTH);

    // R6 ordered commands, upper bits dropped
    wr(8'hE0, 32'hABCD_1234); cmd_exp.push_back(16'h1234);
    wr(8'hE0, 32'h0000_5678); cmd_exp.push_back(16'h5678);
    wr(8'hE0, 32'h0000_9ABC); cmd_exp.push_back(16'h9ABC);
    rd(8'hD0, rv); chk("R6 room after 3", rv, DEPTH - 3);
    @(posedge clk); #1 cmd_ready = 1'b1;
    repeat (6) @(posedge clk);
    chk("R6 drained", cmd_exp.size(), 0);
    #1 cmd_ready = 1'b0;

    // R9 overfill command queue
    for (int i = 0; i < 10; i++) begin
      wr(8'hE0, 32'h100 + i);
      if (i < DEPTH) cmd_exp.push_back(16'(32'h100 + i));
    end
    rd(8'hD0, rv); chk("R9 cmd full room", rv, 32'd0);
    // R12 toggled ready drains in order
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #1 cmd_ready = (i % 3 == 2);
    end
    @(posedge clk); #1 cmd_ready = 1'b1;
    repeat (10) @(posedge clk);
    chk("R9 only first 8 delivered", cmd_exp.size(), 0);
    #1 cmd_ready = 1'b0;

    // R7 transmit queue
    wr(8'hE4, 32'hDEAD_BEEF); txd_exp.push_back(32'hDEAD_BEEF);
    wr(8'hE4, 32'h0BAD_F00D); txd_exp.push_back(32'h0BAD_F00D);
    rd(8'hD4, rv); chk("R7 room after 2", rv, DEPTH - 2);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1 txd_ready = i[0];
    end
    repeat (4) @(posedge clk);
    chk("R7 drained", txd_exp.size(), 0);
    #1 txd_ready = 1'b0;

    // R8 receive queue, peek and pop
    rx_push(32'h11); rx_push(32'h22); rx_push(32'h33);
    rd(8'hD8, rv); chk("R8 level 3", rv, 32'd3);
    rd(8'hEC, rv); chk("R8 peek head", rv, 32'h11);
    rd(8'hD8, rv); chk("R8 peek keeps level", rv, 32'd3);
    rd(8'hE8, rv); chk("R8 pop head", rv, 32'h11);
    rd(8'hD8, rv); chk("R8 level after pop", rv, 32'd2);
    rd(8'hE8, rv); chk("R8 pop second", rv, 32'h22);
    rd(8'hE8, rv); chk("R8 pop third", rv, 32'h33);
    rd(8'hE8, rv); chk("R9 empty pop zero", rv, 32'd0);
    rd(8'hD8, rv); chk("R9 empty level", rv, 32'd0);

    // R10 thresholds: low <= 2, high >= 6
    wr(8'h84, 32'hFF);
    rd(8'h84, rv); chk("R10 low bits reassert", rv, 32'h3);
    for (int i = 0; i < 6; i++) rx_push(32'hA0 + i);
    wr(8'h84, 32'hFF);
    rd(8'h84, rv); chk("R10 rx high set", rv, 32'h7);
    rd(8'hE8, rv); chk("R8 pop A0", rv, 32'hA0);
    wr(8'h84, 32'hFF);
    rd(8'h84, rv); chk("R10 rx high gone at 5", rv, 32'h3);
    for (int i = 0; i < 3; i++) wr(8'hE0, 32'h7000 + i);
    wr(8'h84, 32'h1);
    rd(8'h84, rv); chk("R10 cmd low gone at 3", rv, 32'h2);

    // R3/R4/R5 sync events
    sync_evt(8'h5A);
    rd(8'h84, rv); chk("R4 sync pending", rv & 32'h8, 32'h8);
    rd(8'hC0, rv); chk("R5 tag 5A", rv, 32'h5A);
    wr(8'h84, 32'h0);
    rd(8'h84, rv); chk("R3 write zero keeps", rv & 32'h8, 32'h8);
    wr(8'h84, 32'h8);
    rd(8'h84, rv); chk("R3 w1c sync", rv & 32'h8, 32'h0);
    sync_evt(8'hC3);
    rd(8'hC0, rv); chk("R5 tag C3", rv, 32'hC3);

    // R11 masking
    wr(8'h80, 32'h8);
    chk("R11 irq on", {31'd0, irq}, 32'd1);
    rd(8'h88, rv); chk("R11 source masked", rv, 32'h8);
    wr(8'h84, 32'h8);
    chk("R11 irq off", {31'd0, irq}, 32'd0);
    wr(8'h80, 32'h0);

    // R2 soft reset empties and ignores
    wr(8'h40, 32'd1);
    chk("R2 eng_hold", {31'd0, eng_hold}, 32'd1);
    chk("R2 cmd_valid low", {31'd0, cmd_valid}, 32'd0);
    rd(8'hD0, rv); chk("R2 cmd emptied", rv, DEPTH);
    rd(8'hD8, rv); chk("R2 rx emptied", rv, 32'd0);
    wr(8'hE0, 32'h55); wr(8'hE4, 32'h66);
    rd(8'hD0, rv); chk("R2 cmd push ignored", rv, DEPTH);
    rd(8'hD4, rv); chk("R2 txd push ignored", rv, DEPTH);
    chk("R2 rxd_ready low", {31'd0, rxd_ready}, 32'd0);
    wr(8'h84, 32'hFF);
    sync_evt(8'h77);
    rd(8'h84, rv); chk("R4 sync ignored in hold", rv & 32'h8, 32'h0);
    rd(8'hC0, rv); chk("R5 tag unchanged in hold", rv, 32'hC3);
    wr(8'h40, 32'd0);
    chk("R2 released", {31'd0, eng_hold}, 32'd0);

    finish_run();
  end
endmodule